// File: doc/BRIEF.md
# Vertical Timing Pulse Decoder

This block sits behind an adaptive vertical divider. It takes the divider's count (in half-line clocks), its operating mode and its reset strobe. From these it decodes the pulses that the vertical part of a deflection controller needs:

- a charge pulse for the ramp capacitor;
- an inhibit pulse for the first phase detector around the vertical sync (anti-top-flutter);
- the divider's vertical blanking pulse;
- a gate window for the sync noise measurement.

It also produces a 2-bit level select for a three-level sandcastle output. Vertical blanking and the phase-detector inhibit are merged into the lowest nonzero level. The horizontal blanking and burst key inputs take the higher levels.

The mode is captured at each divider reset strobe, so the decoding stays consistent for a whole field even if the mode input moves mid-field. In search mode, vertical blanking begins at the divider reset. In the narrow-window and standard modes it begins at the first equalizing pulse, shortly before the reset. A guard flag, raised when the vertical feedback is out of range, holds the vertical level on for as long as it is asserted. All outputs are registered and follow their inputs by exactly one clock.

Top module: `vtd_top`

## Requirements
- R1: `ramp_o` is high one clock after any cycle with `div_count` below 26 (counts 0 to 25), and low one clock after any other count.
- R2: The field mode is the value of `div_mode` in a cycle where `div_reset` is high, and that cycle already decodes with the new value. A change of `div_mode` without `div_reset` has no effect on any output until the next strobe.
- R3: `vblank_o` is high one clock after counts 0 to 33 and low one clock after counts 34 to 516, in every mode.
- R4: For counts 517 and above, `vblank_o` is high in narrow mode (`div_mode` 1) and standard mode (2). It is low in search mode (0) and no-signal mode (3).
- R5: `atf_o` is high one clock after counts 0 to 9 in every mode, and after counts 517 and above in modes 1 and 2. It is low otherwise.
- R6: The vertical level (code 1) is requested whenever the registered blanking, the anti-top-flutter pulse or the guard is active.
- R7: With `guard_i` high, `sc_level_o` is never 0 one clock later, whatever the count.
- R8: `sc_level_o` encodes 0 = none, 1 = vertical, 2 = horizontal blanking, 3 = burst key. `burst_i` wins over `hblank_i`, which wins over the vertical request.
- R9: `ngate_o` is high one clock after counts 40 to 69 (a 30-count window) and low otherwise.
- R10: While `rst_n` is low, all outputs are 0 and the held field mode is search.

Ports table: the Direction column gives the direction, and the Width column gives the width in bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-line clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_count | input | 10 | Current divider count |
| div_mode | input | 2 | Divider mode: 0 search, 1 narrow, 2 standard, 3 no-signal |
| div_reset | input | 1 | Divider reset strobe (count 0); captures `div_mode` |
| guard_i | input | 1 | Vertical feedback out of range |
| hblank_i | input | 1 | Horizontal blanking request |
| burst_i | input | 1 | Burst key request |
| ramp_o | output | 1 | Ramp capacitor charge pulse |
| atf_o | output | 1 | Phase detector inhibit (anti-top-flutter) |
| vblank_o | output | 1 | Divider vertical blanking |
| ngate_o | output | 1 | Noise measurement gate |
| sc_level_o | output | 2 | Sandcastle level select |

## Verification
The assertions check the following on every cycle:
- the ramp window;
- the quiet span between the blanking end and the first equalizing pulse;
- the search-mode absence of early blanking at the strobe;
- the guard and burst priorities;
- the vertical level that follows any active pulse.

Some behaviours can only be shown by the bench's scenarios, which replay whole fields in each mode and compare every output against a field model:
- that a mode change without a strobe is ignored for the rest of the field;
- the exact start of blanking at count 517 in the two locked modes;
- the placement of the noise gate.

// File: rtl/vtd_pkg.sv
`timescale 1ns/1ps
package vtd_pkg;

  typedef enum logic [1:0] {
    VM_SEARCH   = 2'd0,
    VM_NARROW   = 2'd1,
    VM_STANDARD = 2'd2,
    VM_NOSIG    = 2'd3
  } vmode_e;

  typedef enum logic [1:0] {
    SC_NONE  = 2'd0,
    SC_VERT  = 2'd1,
    SC_HORIZ = 2'd2,
    SC_BURST = 2'd3
  } sclev_e;

  // true when the mode opens blanking at the first equalizing pulse
  function automatic logic early_start(vmode_e m);
    return (m == VM_NARROW) || (m == VM_STANDARD);
  endfunction

  // half-open span test on 16-bit counts: lo <= c < hi
  function automatic logic in_span(logic [15:0] c, logic [15:0] lo, logic [15:0] hi);
    return (c >= lo) && (c < hi);
  endfunction

endpackage

// File: rtl/vtd_mode_hold.sv
`timescale 1ns/1ps
module vtd_mode_hold
  import vtd_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   strobe,
  input  vmode_e mode_in,
  output vmode_e eff_mode
);
  vmode_e held_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      held_q <= VM_SEARCH;
    else if (strobe) held_q <= mode_in;
  end

  // the strobe cycle already decodes with the new mode
  assign eff_mode = strobe ? mode_in : held_q;
endmodule

// File: rtl/vtd_pulse_decode.sv
`timescale 1ns/1ps
module vtd_pulse_decode
  import vtd_pkg::*;
#(
  parameter int CW        = 10,
  parameter int RAMP_LEN  = 26,
  parameter int BLANK_END = 34,
  parameter int ATF_END   = 10,
  parameter int EQ_START  = 517,
  parameter int NG_START  = 40,
  parameter int NG_END    = 70
) (
  input  logic [CW-1:0] cnt,
  input  vmode_e        mode,
  output logic          ramp,
  output logic          atf,
  output logic          blank,
  output logic          ngate
);
  localparam int PAD = 16 - CW;
  localparam logic [15:0] TOP = 16'hFFFF;

  logic [15:0] c16;
  logic        early;
  logic        pre_window;

  assign c16        = {{PAD{1'b0}}, cnt};
  assign early      = early_start(mode);
  assign pre_window = early && in_span(c16, 16'(EQ_START), TOP);

  always_comb begin
    ramp  = in_span(c16, 16'd0, 16'(RAMP_LEN));
    blank = in_span(c16, 16'd0, 16'(BLANK_END)) || pre_window;
    atf   = in_span(c16, 16'd0, 16'(ATF_END))   || pre_window;
    ngate = in_span(c16, 16'(NG_START), 16'(NG_END));
  end
endmodule

// File: rtl/vtd_level_encode.sv
`timescale 1ns/1ps
module vtd_level_encode
  import vtd_pkg::*;
(
  input  logic   burst,
  input  logic   hblank,
  input  logic   vert,
  output sclev_e level
);
  always_comb begin
    if (burst)       level = SC_BURST;
    else if (hblank) level = SC_HORIZ;
    else if (vert)   level = SC_VERT;
    else             level = SC_NONE;
  end
endmodule

// File: rtl/vtd_top.sv
`timescale 1ns/1ps
module vtd_top
  import vtd_pkg::*;
#(
  parameter int CW        = 10,
  parameter int RAMP_LEN  = 26,
  parameter int BLANK_END = 34,
  parameter int ATF_END   = 10,
  parameter int EQ_START  = 517,
  parameter int NG_START  = 40,
  parameter int NG_END    = 70
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] div_count,
  input  logic [1:0]    div_mode,
  input  logic          div_reset,
  input  logic          guard_i,
  input  logic          hblank_i,
  input  logic          burst_i,
  output logic          ramp_o,
  output logic          atf_o,
  output logic          vblank_o,
  output logic          ngate_o,
  output logic [1:0]    sc_level_o
);
  // named internal events, visible to the checker
  vmode_e eff_mode;
  logic   ramp_d, atf_d, blank_d, ngate_d;
  logic   vert_req;
  sclev_e level_d;

  vtd_mode_hold u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (div_reset),
    .mode_in  (vmode_e'(div_mode)),
    .eff_mode (eff_mode)
  );

  vtd_pulse_decode #(
    .CW(CW), .RAMP_LEN(RAMP_LEN), .BLANK_END(BLANK_END), .ATF_END(ATF_END),
    .EQ_START(EQ_START), .NG_START(NG_START), .NG_END(NG_END)
  ) u_dec (
    .cnt   (div_count),
    .mode  (eff_mode),
    .ramp  (ramp_d),
    .atf   (atf_d),
    .blank (blank_d),
    .ngate (ngate_d)
  );

  assign vert_req = blank_d | atf_d | guard_i;

  vtd_level_encode u_lvl (
    .burst  (burst_i),
    .hblank (hblank_i),
    .vert   (vert_req),
    .level  (level_d)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ramp_o     <= 1'b0;
      atf_o      <= 1'b0;
      vblank_o   <= 1'b0;
      ngate_o    <= 1'b0;
      sc_level_o <= 2'd0;
    end else begin
      ramp_o     <= ramp_d;
      atf_o      <= atf_d;
      vblank_o   <= blank_d;
      ngate_o    <= ngate_d;
      sc_level_o <= level_d;
    end
  end
endmodule

// File: rtl/vtd_checker.sv
`timescale 1ns/1ps
module vtd_checker #(
  parameter int CW        = 10,
  parameter int RAMP_LEN  = 26,
  parameter int BLANK_END = 34,
  parameter int EQ_START  = 517
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] div_count,
  input logic [1:0]    div_mode,
  input logic          div_reset,
  input logic          guard_i,
  input logic          hblank_i,
  input logic          burst_i,
  input logic          ramp_o,
  input logic          atf_o,
  input logic          vblank_o,
  input logic [1:0]    sc_level_o
);
  AST_RAMP_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (div_count < CW'(RAMP_LEN)) |=> ramp_o);  // R1
  AST_RAMP_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (div_count >= CW'(RAMP_LEN)) |=> !ramp_o);  // R1
  AST_QUIET_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    (div_count >= CW'(BLANK_END) && div_count < CW'(EQ_START)) |=> (!vblank_o && !atf_o));  // R3
  AST_SEARCH_NO_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
    (div_reset && div_mode == 2'd0 && div_count >= CW'(EQ_START)) |=> !vblank_o);  // R4
  AST_GUARD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    guard_i |=> (sc_level_o != 2'd0));  // R7
  AST_BURST_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    burst_i |=> (sc_level_o == 2'd3));  // R8
  AST_HORIZ_OVER_VERT: assert property (@(posedge clk) disable iff (!rst_n)
    (hblank_i && !burst_i) |=> (sc_level_o == 2'd2));  // R8
  AST_VERT_SHOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (atf_o || vblank_o) |-> (sc_level_o != 2'd0));  // R6
endmodule

bind vtd_top vtd_checker #(
  .CW(CW), .RAMP_LEN(RAMP_LEN), .BLANK_END(BLANK_END), .EQ_START(EQ_START)
) u_chk (
  .clk(clk), .rst_n(rst_n), .div_count(div_count), .div_mode(div_mode),
  .div_reset(div_reset), .guard_i(guard_i), .hblank_i(hblank_i), .burst_i(burst_i),
  .ramp_o(ramp_o), .atf_o(atf_o), .vblank_o(vblank_o), .sc_level_o(sc_level_o)
);

// File: tb/sim_vtd_top.sv
`timescale 1ns/1ps
module sim_vtd_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] div_count = '0;
  logic [1:0] div_mode = '0;
  logic       div_reset = 1'b0;
  logic       guard_i = 1'b0;
  logic       hblank_i = 1'b0;
  logic       burst_i = 1'b0;
  logic       ramp_o, atf_o, vblank_o, ngate_o;
  logic [1:0] sc_level_o;

  always #2.5 clk = ~clk;

  vtd_top u0 (
    .clk(clk), .rst_n(rst_n), .div_count(div_count), .div_mode(div_mode),
    .div_reset(div_reset), .guard_i(guard_i), .hblank_i(hblank_i), .burst_i(burst_i),
    .ramp_o(ramp_o), .atf_o(atf_o), .vblank_o(vblank_o), .ngate_o(ngate_o),
    .sc_level_o(sc_level_o)
  );

  typedef struct packed {
    logic [9:0] cnt;
    logic       ramp, atf, blank, ngate;
    logic [1:0] lvl;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   fails = 0;
  logic [1:0] model_mode = 2'd0;
  bit   done = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // driver: applies one cycle of inputs and queues what must appear next clock
  task automatic drive(input int c, input logic [1:0] m, input bit strobe,
                       input bit g, input bit hb, input bit bk);
    exp_t e;
    logic [1:0] fm;
    bit locked, vert;
    @(negedge clk);
    div_count = 10'(c); div_mode = m; div_reset = strobe;
    guard_i = g; hblank_i = hb; burst_i = bk;
    if (strobe) model_mode = m;
    fm = model_mode;
    locked = (fm == 2'd1) || (fm == 2'd2);
    e.cnt   = 10'(c);
    e.ramp  = (c <= 25);
    e.blank = (c <= 33) || (locked && c >= 517);
    e.atf   = (c <= 9)  || (locked && c >= 517);
    e.ngate = (c >= 40) && (c <= 69);
    vert    = e.blank || e.atf || g;
    e.lvl   = bk ? 2'd3 : (hb ? 2'd2 : (vert ? 2'd1 : 2'd0));
    exp_q.push_back(e);
  endtask

  // one field of 528 counts; mode changes to late_m at count 200 without strobe
  task automatic field(input logic [1:0] m, input logic [1:0] late_m,
                       input int g_lo, input int g_hi, input bit pulses);
    for (int c = 0; c < 528; c++) begin
      drive(c, (c >= 200) ? late_m : m, c == 0, (c >= g_lo && c < g_hi),
            pulses && (c % 7 == 3), pulses && (c % 11 == 5));
    end
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk); #1;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        chk(ramp_o == e.ramp, "R1", $sformatf("ramp cnt=%0d", e.cnt), ramp_o, e.ramp);
        chk(vblank_o == e.blank, (e.cnt >= 517) ? "R4/R2" : "R3",
            $sformatf("vblank cnt=%0d", e.cnt), vblank_o, e.blank);
        chk(atf_o == e.atf, "R5", $sformatf("atf cnt=%0d", e.cnt), atf_o, e.atf);
        chk(ngate_o == e.ngate, "R9", $sformatf("ngate cnt=%0d", e.cnt), ngate_o, e.ngate);
        chk(sc_level_o == e.lvl, "R6/R7/R8", $sformatf("level cnt=%0d", e.cnt), sc_level_o, e.lvl);
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1;
    // R10: reset state
    chk(ramp_o == 0 && atf_o == 0 && vblank_o == 0 && ngate_o == 0, "R10", "pulses in reset",
        {ramp_o, atf_o, vblank_o, ngate_o}, 0);
    chk(sc_level_o == 0, "R10", "level in reset", sc_level_o, 0);
    @(negedge clk); rst_n = 1'b1;
    // R10: held mode is search after reset, before any strobe
    drive(520, 2'd1, 0, 0, 0, 0);
    field(2'd0, 2'd0, -1, -1, 0);       // search
    field(2'd1, 2'd1, -1, -1, 0);       // narrow
    field(2'd2, 2'd0, -1, -1, 1);       // standard, late change ignored (R2), priority (R8)
    field(2'd0, 2'd2, 100, 300, 0);     // search, late change ignored (R2), guard (R7)
    field(2'd3, 2'd3, 500, 528, 1);     // no-signal behaves as search (R4)
    field(2'd1, 2'd1, 0, 528, 1);       // guard whole field (R7)
    drive(0, 2'd2, 1, 0, 0, 0);         // strobe cycle already uses new mode (R2)
    drive(517, 2'd0, 0, 0, 0, 0);
    drive(520, 2'd0, 1, 0, 0, 0);       // strobe to search at late count (R4)
    drive(40, 2'd0, 0, 0, 0, 0);
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule